// File: doc/BRIEF.md
# Sequential Buffer Address Pointer

This block produces the word address for a clocked, streaming port into a 4096-word memory. A 12-bit pointer register can step forward by one, take a value supplied on the data inputs, or jump to one of two programmable start addresses. The memory array and its output drivers sit elsewhere. This block only decides which word the streaming port touches on each clock.

The data-input path goes through a capture register, so a direct load is seen on the pointer one clock after the edge that sampled it. Each of two channels pairs a start register with an end register. The end register drives an active-low, sticky flag that drops when a forward step lands on the stored address. A small command port writes the start and end registers. It also writes a control word that releases either flag. If a start strobe is given while a direct load is in progress, the strobe is ignored and a one-cycle protocol error is reported. All control inputs are active-low and sampled on the rising clock edge. Reset is synchronous and active-high.

Top module: `sbuf_addr_ptr`

## Requirements
- R1: While `rst` is high at a rising edge, the pointer becomes 0, both `eob_n` bits become 1, `proto_err` becomes 0, both start registers become 0 and both end registers become 4095.
- R2: On an edge with `en_n`=0 and `cnt_n`=0, and no higher-priority action, the pointer becomes its old value plus one. 4095 steps to 0.
- R3: On an edge with `en_n`=0 and `ld_n`=0, bits [11:0] of `din` are captured. The pointer takes that value on the next edge. That next-edge load takes priority over any other action on that edge and happens whatever `en_n` is.
- R4: On an edge with `en_n`=0 and `strt_n[i]`=0, with no pending direct load, the pointer takes start register i. Strobe bit 0 takes precedence over bit 1, and any strobe takes precedence over counting.
- R5: A strobe sampled low in either of two situations is ignored: while `ld_n` is sampled low, or on the edge right after a direct-load capture. In both cases `proto_err` is 1 for exactly the following cycle.
- R6: `eob_n[i]` goes to 0 on an edge where a count step makes the pointer equal to end register i. A load or strobe that lands on that value does not change the flag.
- R7: Once 0, `eob_n[i]` stays 0 through later steps and loads until reset or a clear.
- R8: A command write to address 5 with data bit i equal to 0 sets `eob_n[i]` to 1 on that edge. Data bit i equal to 1 leaves the flag alone. If a set and a clear happen on the same edge, the set wins.
- R9: On an edge with `en_n`=1, the count, direct-load and strobe inputs have no effect. A capture made on the edge before still completes.
- R10: A command write takes bits [11:0] of `cmd_wdata`. Address 0 writes start register 0, address 1 writes start register 1, address 2 writes end register 0 and address 3 writes end register 1. The new value is used from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Port enable, active low |
| cnt_n | input | 1 | Count step request, active low |
| ld_n | input | 1 | Direct-load request, active low |
| strt_n | input | 2 | Start strobes per channel, active low |
| din | input | 16 | Data inputs for direct load |
| cmd_we | input | 1 | Command register write strobe |
| cmd_addr | input | 3 | Command register address |
| cmd_wdata | input | 16 | Command register write data |
| ptr | output | 12 | Current pointer value |
| eob_n | output | 2 | Sticky end-of-buffer flags, active low |
| proto_err | output | 1 | Strobe-during-load protocol error pulse |

## Verification
The bench builds the block with its default values: a 12-bit pointer, 16-bit data, two channels and a 3-bit command address. With a 12-bit pointer, the wrap from 4095 to 0 and the reset end value of 4095 can be reached in a few clocks, by direct-loading a value just below the top and stepping. With two channels, the bench can test strobe precedence, and it can show that a set or clear of one flag leaves the other flag unchanged.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    localparam int PTR_W_D     = 12;
    localparam int WORD_W_D    = 16;
    localparam int CH_N_D      = 2;
    localparam int CMD_AW_D    = 3;
    localparam int CTRL_ADDR_D = 5;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_COUNT,
        OP_START,
        OP_DIRECT
    } ptr_op_e;

    typedef struct packed {
        logic active;
        logic count;
        logic load;
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic en_n, input logic cnt_n, input logic ld_n);
        ctl_t c;
        c.active = !en_n;
        c.count  = !en_n && !cnt_n;
        c.load   = !en_n && !ld_n;
        return c;
    endfunction
endpackage

// File: rtl/sbuf_cmd_regs.sv
module sbuf_cmd_regs #(
    parameter int PTR_W     = 12,
    parameter int WORD_W    = 16,
    parameter int CH_N      = 2,
    parameter int CMD_AW    = 3,
    parameter int CTRL_ADDR = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_we,
    input  logic [CMD_AW-1:0]          cmd_addr,
    input  logic [WORD_W-1:0]          cmd_wdata,
    output logic [CH_N-1:0][PTR_W-1:0] start_q,
    output logic [CH_N-1:0][PTR_W-1:0] end_q,
    output logic [CH_N-1:0]            clr
);
    localparam logic [PTR_W-1:0] END_RST = {PTR_W{1'b1}};

    logic unused_hi;
    assign unused_hi = ^cmd_wdata[WORD_W-1:PTR_W];

    logic ctrl_hit;
    assign ctrl_hit = cmd_we && (cmd_addr == CMD_AW'(CTRL_ADDR));

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        assign clr[i] = ctrl_hit && !cmd_wdata[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                start_q[i] <= '0;
                end_q[i]   <= END_RST;
            end else if (cmd_we) begin
                if (cmd_addr == CMD_AW'(i))
                    start_q[i] <= cmd_wdata[PTR_W-1:0];
                if (cmd_addr == CMD_AW'(CH_N + i))
                    end_q[i] <= cmd_wdata[PTR_W-1:0];
            end
        end

        p_endwr_r10: assert property (@(posedge clk) disable iff (rst)
            (cmd_we && cmd_addr == CMD_AW'(CH_N + i)) |=> end_q[i] == $past(cmd_wdata[PTR_W-1:0]));
    end
endmodule

// File: rtl/sbuf_load_stage.sv
module sbuf_load_stage #(
    parameter int PTR_W  = 12,
    parameter int WORD_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  sbuf_pkg::ctl_t   ctl,
    input  logic             strobe_any,
    input  logic [WORD_W-1:0] din,
    output logic [PTR_W-1:0] din_q,
    output logic             pend,
    output logic             strobe_block,
    output logic             proto_err
);
    logic unused_hi;
    assign unused_hi = ^din[WORD_W-1:PTR_W];

    assign strobe_block = strobe_any && (ctl.load || pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q     <= '0;
            pend      <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            pend      <= ctl.load;
            proto_err <= strobe_block;
            if (ctl.load)
                din_q <= din[PTR_W-1:0];
        end
    end

    p_pend_r3: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> pend);
    p_err_r5: assert property (@(posedge clk) disable iff (rst)
        strobe_block |=> proto_err);
    p_errpulse_r5: assert property (@(posedge clk) disable iff (rst)
        !strobe_block |=> !proto_err);
endmodule

// File: rtl/sbuf_ptr_core.sv
module sbuf_ptr_core #(
    parameter int PTR_W = 12,
    parameter int CH_N  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  sbuf_pkg::ctl_t             ctl,
    input  logic [CH_N-1:0]            strb,
    input  logic                       strobe_block,
    input  logic                       pend,
    input  logic [PTR_W-1:0]           din_q,
    input  logic [CH_N-1:0][PTR_W-1:0] start_q,
    output logic [PTR_W-1:0]           ptr_q,
    output logic                       inc_fire,
    output logic [PTR_W-1:0]           inc_val
);
    import sbuf_pkg::*;

    localparam int SEL_W = (CH_N > 1) ? $clog2(CH_N) : 1;

    ptr_op_e          op;
    logic [SEL_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = CH_N - 1; i >= 0; i--)
            if (strb[i]) sel = SEL_W'(i);
    end

    always_comb begin
        if (pend)
            op = OP_DIRECT;
        else if (|strb && !strobe_block)
            op = OP_START;
        else if (ctl.count)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

    assign inc_val  = ptr_q + PTR_W'(1);
    assign inc_fire = (op == OP_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            unique case (op)
                OP_DIRECT: ptr_q <= din_q;
                OP_START:  ptr_q <= start_q[sel];
                OP_COUNT:  ptr_q <= inc_val;
                default:   ptr_q <= ptr_q;
            endcase
        end
    end

    p_direct_r3: assert property (@(posedge clk) disable iff (rst)
        pend |=> ptr_q == $past(din_q));
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.count && !pend && strb == '0) |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)));
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctl.active && !pend) |=> $stable(ptr_q));
endmodule

// File: rtl/sbuf_flags.sv
module sbuf_flags #(
    parameter int PTR_W = 12,
    parameter int CH_N  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       inc_fire,
    input  logic [PTR_W-1:0]           inc_val,
    input  logic [PTR_W-1:0]           ptr_q,
    input  logic [CH_N-1:0][PTR_W-1:0] end_q,
    input  logic [CH_N-1:0]            clr,
    output logic [CH_N-1:0]            eob_n
);
    for (genvar i = 0; i < CH_N; i++) begin : g_flag
        logic hit;
        assign hit = inc_fire && (inc_val == end_q[i]);

        always_ff @(posedge clk) begin
            if (rst)
                eob_n[i] <= 1'b1;
            else if (hit)
                eob_n[i] <= 1'b0;
            else if (clr[i])
                eob_n[i] <= 1'b1;
        end

        p_set_r6: assert property (@(posedge clk) disable iff (rst)
            $fell(eob_n[i]) |-> ptr_q == $past(end_q[i]));
        p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            (!eob_n[i] && !clr[i]) |=> !eob_n[i]);
        p_clear_r8: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !hit) |=> eob_n[i]);
    end
endmodule

// File: rtl/sbuf_addr_ptr.sv
module sbuf_addr_ptr #(
    parameter int PTR_W     = sbuf_pkg::PTR_W_D,
    parameter int WORD_W    = sbuf_pkg::WORD_W_D,
    parameter int CH_N      = sbuf_pkg::CH_N_D,
    parameter int CMD_AW    = sbuf_pkg::CMD_AW_D,
    parameter int CTRL_ADDR = sbuf_pkg::CTRL_ADDR_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              cnt_n,
    input  logic              ld_n,
    input  logic [CH_N-1:0]   strt_n,
    input  logic [WORD_W-1:0] din,
    input  logic              cmd_we,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic [PTR_W-1:0]  ptr,
    output logic [CH_N-1:0]   eob_n,
    output logic              proto_err
);
    import sbuf_pkg::*;

    ctl_t                       ctl;
    logic [CH_N-1:0]            strb;
    logic [CH_N-1:0][PTR_W-1:0] start_q;
    logic [CH_N-1:0][PTR_W-1:0] end_q;
    logic [CH_N-1:0]            clr;
    logic [PTR_W-1:0]           din_q;
    logic                       pend;
    logic                       strobe_block;
    logic                       inc_fire;
    logic [PTR_W-1:0]           inc_val;

    assign ctl  = decode_ctl(en_n, cnt_n, ld_n);
    assign strb = ctl.active ? ~strt_n : '0;

    sbuf_cmd_regs #(.PTR_W(PTR_W), .WORD_W(WORD_W), .CH_N(CH_N),
                    .CMD_AW(CMD_AW), .CTRL_ADDR(CTRL_ADDR)) u_regs (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .start_q(start_q), .end_q(end_q), .clr(clr)
    );

    sbuf_load_stage #(.PTR_W(PTR_W), .WORD_W(WORD_W)) u_load (
        .clk(clk), .rst(rst), .ctl(ctl), .strobe_any(|strb), .din(din),
        .din_q(din_q), .pend(pend), .strobe_block(strobe_block),
        .proto_err(proto_err)
    );

    sbuf_ptr_core #(.PTR_W(PTR_W), .CH_N(CH_N)) u_core (
        .clk(clk), .rst(rst), .ctl(ctl), .strb(strb),
        .strobe_block(strobe_block), .pend(pend), .din_q(din_q),
        .start_q(start_q), .ptr_q(ptr), .inc_fire(inc_fire), .inc_val(inc_val)
    );

    sbuf_flags #(.PTR_W(PTR_W), .CH_N(CH_N)) u_flags (
        .clk(clk), .rst(rst), .inc_fire(inc_fire), .inc_val(inc_val),
        .ptr_q(ptr), .end_q(end_q), .clr(clr), .eob_n(eob_n)
    );

    p_rst_r1: assert property (@(posedge clk)
        rst |=> (ptr == '0 && eob_n == '1 && !proto_err));
endmodule

// File: tb/sbuf_addr_ptr_bench.sv
module sbuf_addr_ptr_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_n = 1'b1, cnt_n = 1'b1, ld_n = 1'b1;
    logic [1:0]  strt_n = 2'b11;
    logic [15:0] din = '0;
    logic        cmd_we = 1'b0;
    logic [2:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic [11:0] ptr;
    logic [1:0]  eob_n;
    logic        proto_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sbuf_addr_ptr u_sbuf_addr_ptr (
        .clk(clk), .rst(rst), .en_n(en_n), .cnt_n(cnt_n), .ld_n(ld_n),
        .strt_n(strt_n), .din(din), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .ptr(ptr), .eob_n(eob_n), .proto_err(proto_err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        en_n = 1'b1; cnt_n = 1'b1; ld_n = 1'b1; strt_n = 2'b11; cmd_we = 1'b0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        idle();
        cmd_we = 1'b1; cmd_addr = a; cmd_wdata = d;
        tick();
        cmd_we = 1'b0;
    endtask

    task automatic dload(input logic [15:0] d);
        idle();
        en_n = 1'b0; ld_n = 1'b0; din = d;
        tick();
        idle();
        tick();
    endtask

    task automatic step(input int n);
        idle();
        en_n = 1'b0; cnt_n = 1'b0;
        for (int k = 0; k < n; k++) tick();
        idle();
    endtask

    task automatic t_reset_wrap();
        do_reset();
        chk("R1 ptr", ptr, 0);
        chk("R1 eob_n", eob_n, 2'b11);
        chk("R1 proto_err", proto_err, 0);
        dload(16'd4093);
        chk("R3 load 4093", ptr, 4093);
        step(1);
        chk("R2 step", ptr, 4094);
        chk("R6 no match yet", eob_n, 2'b11);
        step(1);
        chk("R1 end default 4095 / R6", eob_n, 2'b00);
        step(1);
        chk("R2 wrap", ptr, 0);
        chk("R7 flags held", eob_n, 2'b00);
    endtask

    task automatic t_regs_count();
        do_reset();
        wr(3'd0, 16'hF064);
        wr(3'd1, 16'h00C8);
        wr(3'd2, 16'h0067);
        wr(3'd3, 16'h00CD);
        en_n = 1'b0; strt_n = 2'b10; tick(); idle();
        chk("R10 start0 / R4", ptr, 100);
        en_n = 1'b0; strt_n = 2'b01; tick(); idle();
        chk("R10 start1 / R4", ptr, 200);
        en_n = 1'b0; strt_n = 2'b10; tick(); idle();
        step(2);
        chk("R2 count", ptr, 102);
        chk("R6 before end", eob_n, 2'b11);
        step(1);
        chk("R6 end0 match", eob_n, 2'b10);
        step(1);
        chk("R7 sticky", eob_n, 2'b10);
        wr(3'd5, 16'h0002);
        chk("R8 clear bit0", eob_n, 2'b11);
        en_n = 1'b0; strt_n = 2'b10; tick(); idle();
        step(2);
        cmd_we = 1'b1; cmd_addr = 3'd5; cmd_wdata = 16'h0000;
        en_n = 1'b0; cnt_n = 1'b0;
        tick(); idle();
        chk("R8 set wins", eob_n, 2'b10);
    endtask

    task automatic t_load_no_set();
        do_reset();
        wr(3'd1, 16'd205);
        wr(3'd3, 16'd205);
        en_n = 1'b0; strt_n = 2'b01; tick(); idle();
        chk("R4 strobe to 205", ptr, 205);
        chk("R6 strobe no set", eob_n, 2'b11);
        dload(16'd205);
        chk("R6 load no set", eob_n, 2'b11);
        dload(16'd204);
        step(1);
        chk("R6 end1 match", eob_n, 2'b01);
    endtask

    task automatic t_direct();
        do_reset();
        en_n = 1'b0; ld_n = 1'b0; din = 16'hA123;
        tick(); idle();
        chk("R3 not same edge", ptr, 0);
        tick();
        chk("R3 next edge", ptr, 12'h123);
        en_n = 1'b0; ld_n = 1'b0; cnt_n = 1'b0; din = 16'h0050;
        tick();
        chk("R3 count on capture edge", ptr, 12'h124);
        tick(); idle();
        chk("R3 load beats count", ptr, 12'h050);
    endtask

    task automatic t_prio();
        do_reset();
        wr(3'd0, 16'd7);
        wr(3'd1, 16'd9);
        en_n = 1'b0; strt_n = 2'b00; tick(); idle();
        chk("R4 strobe0 first", ptr, 7);
        en_n = 1'b0; strt_n = 2'b01; cnt_n = 1'b0; tick(); idle();
        chk("R4 strobe beats count", ptr, 9);
    endtask

    task automatic t_proto();
        do_reset();
        wr(3'd0, 16'd33);
        en_n = 1'b0; ld_n = 1'b0; strt_n = 2'b10; din = 16'd44;
        tick(); idle();
        chk("R5 err with ld", proto_err, 1);
        chk("R5 strobe ignored", ptr, 0);
        tick();
        chk("R5 err one cycle", proto_err, 0);
        chk("R5 load done", ptr, 44);
        en_n = 1'b0; ld_n = 1'b0; din = 16'd55;
        tick(); idle();
        en_n = 1'b0; strt_n = 2'b10;
        tick(); idle();
        chk("R5 err after ld", proto_err, 1);
        chk("R5 pending wins", ptr, 55);
    endtask

    task automatic t_disable();
        do_reset();
        wr(3'd0, 16'd77);
        en_n = 1'b1; cnt_n = 1'b0; tick(); idle();
        chk("R9 count ignored", ptr, 0);
        en_n = 1'b1; ld_n = 1'b0; din = 16'd88; tick(); idle();
        tick();
        chk("R9 load ignored", ptr, 0);
        en_n = 1'b1; strt_n = 2'b10; tick(); idle();
        chk("R9 strobe ignored", ptr, 0);
        en_n = 1'b0; ld_n = 1'b0; din = 16'd99; tick(); idle();
        en_n = 1'b1; tick();
        chk("R9 pending completes", ptr, 99);
    endtask

    initial begin
        @(negedge clk);
        t_reset_wrap();
        t_regs_count();
        t_load_no_set();
        t_direct();
        t_prio();
        t_proto();
        t_disable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule